// File: doc/BRIEF.md
# Byte-Order Data Staging Buffer

This block sits between a 16-bit host data register and a byte-serial transfer sequencer. It holds up to four bytes in a single shift register that serves both directions. On the transmit side the host pushes either a 16-bit word, which adds two bytes, or a single byte. The sequencer then takes bytes out in the order they were written. On the receive side the sequencer drops incoming bytes into successive byte lanes starting at lane 0. The host takes them out two at a time through a 16-bit read port. A big-endian input chooses which byte of a host word goes first, and it applies to both writes and reads.

Transmit and receive each have their own fill count. Alongside the data the block keeps a small set of status flags: single leftover byte, receive overrun, transmit underflow, transmit ready, receive ready and access ready. It also emits two one-cycle pulses. One tells the surrounding controller to drop master mode. The other retriggers the sequencer after every host read.

Only one operation takes effect per cycle. When several requests arrive together, the order of precedence is: host read, 16-bit write, 8-bit write, transmit pop, receive push. The lower-priority requests in that cycle are dropped.

Top module: `stg_byte_buffer`

## Requirements
- R1: After reset both fill counts are 0, every flag and pulse output is 0, and rd_data and seq_tx_byte read 0.
- R2: With big_endian low, a 16-bit write adds 2 to tx_count, and the sequencer receives the low byte of the word before the high byte. seq_tx_byte always shows the oldest held transmit byte, or 0 when none is held. Each pop removes that byte.
- R3: With big_endian high, a 16-bit write puts the high byte of the word first in transmit order.
- R4: An 8-bit write (host_wdata[7:0]) adds exactly one byte to tx_count. That byte is sent after every byte already held.
- R5: A 16-bit or 8-bit write made while tx_count is above 2 changes nothing: counts, transmit order and flags stay as they were.
- R6: Every accepted write clears the underflow flag. It also clears the transmit-ready flag when tx_count is above 2 after the write.
- R7: A received byte lands in byte lane rx_count. rd_data shows lane 1 in bits 15:8 and lane 0 in bits 7:0. When big_endian is high, these two bytes are swapped.
- R8: A read with two or more bytes held lowers rx_count by 2. If more than two were held, the remaining bytes move down two lanes.
- R9: A read with exactly one byte held sets the single-byte flag and sets rx_count to 0.
- R10: A read that leaves rx_count at 0 clears receive ready. If, in addition, master_active and dir_rx are both high, the read sets access ready and pulses master_clr for one cycle.
- R11: Every read clears the overrun flag and pulses seq_kick for one cycle. Both take effect in the cycle after the read.
- R12: A read with no bytes held returns the current low 16 bits of the buffer and leaves both counts unchanged.
- R13: A received byte that arrives when four bytes are held is dropped and sets the overrun flag. A byte that is accepted sets receive ready.
- R14: Each bit of status_clr clears one flag: bit 0 access ready, bit 1 receive ready, bit 2 transmit ready, bit 3 underflow, bit 4 overrun, bit 5 single byte. The clears are applied before tx_udf_set and tx_rdy_set, which set underflow and transmit ready. Operation effects take precedence over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | Byte-swap select for host reads and writes |
| host_wr16 | input | 1 | 16-bit data write |
| host_wr8 | input | 1 | 8-bit data write (uses host_wdata[7:0]) |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host data read (pop two bytes) |
| rd_data | output | 16 | Read data, shown from the held state |
| seq_tx_pop | input | 1 | Sequencer takes one transmit byte |
| seq_tx_byte | output | 8 | Oldest held transmit byte |
| seq_rx_push | input | 1 | Sequencer delivers one received byte |
| seq_rx_byte | input | 8 | Received byte |
| tx_udf_set | input | 1 | Sets the underflow flag |
| tx_rdy_set | input | 1 | Sets the transmit-ready flag |
| status_clr | input | 6 | Write-one-to-clear flag mask |
| master_active | input | 1 | Controller is in master mode |
| dir_rx | input | 1 | Transfer direction is receive |
| tx_count | output | 3 | Transmit bytes held |
| rx_count | output | 3 | Receive bytes held |
| flag_single | output | 1 | Single leftover byte was read |
| flag_overrun | output | 1 | Receive overrun |
| flag_underflow | output | 1 | Transmit underflow |
| flag_tx_ready | output | 1 | Transmit ready |
| flag_rx_ready | output | 1 | Receive ready |
| flag_access_ready | output | 1 | Access ready |
| master_clr | output | 1 | One-cycle request to leave master mode |
| seq_kick | output | 1 | One-cycle sequencer retrigger after a read |

## Verification
rd_data and seq_tx_byte are combinational views of the stored bytes. The bench samples them at the falling edge just before the clock edge that consumes them. Counts, flags, master_clr and seq_kick come from registers. Each is due exactly one rising edge after the operation, and the bench compares them at the following falling edge against a bench-side model advanced by that same single operation. Directed cases pin byte order, the write guard, the one-byte read, the empty read and overrun to literal values. Seeded random operations then cover interleavings of these behaviours.

// File: rtl/stg_pkg.sv
package stg_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_RD,
        OP_WR16,
        OP_WR8,
        OP_TXPOP,
        OP_RXPUSH
    } op_e;

    // bit order matches the status_clr mask: single is bit 5, access ready bit 0
    typedef struct packed {
        logic single;
        logic ovr;
        logic udf;
        logic txr;
        logic rxr;
        logic acc;
    } flags_t;

    typedef struct packed {
        logic wr_ok;
        logic wr_deep;
        logic rx_ok;
        logic rx_drop;
        logic rd;
        logic rd_single;
        logic rd_drained;
    } evt_t;

endpackage

// File: rtl/stg_store.sv
module stg_store
    import stg_pkg::*;
#(
    parameter  int NBYTES = 4,
    localparam int CNT_W  = $clog2(NBYTES + 1),
    localparam int BUF_W  = NBYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op_i,
    input  logic             big_endian_i,
    input  logic [15:0]      wr_data_i,
    input  logic [7:0]       rx_byte_i,
    output logic [15:0]      rd_data_o,
    output logic [7:0]       tx_byte_o,
    output logic [CNT_W-1:0] tx_cnt_o,
    output logic [CNT_W-1:0] rx_cnt_o,
    output evt_t             evt_o
);

    typedef struct packed {
        logic [BUF_W-1:0] data;
        logic [CNT_W-1:0] tx;
        logic [CNT_W-1:0] rx;
    } st_t;

    localparam logic [CNT_W-1:0] WR_LIMIT = CNT_W'(NBYTES - 2);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(NBYTES);

    st_t         st_d, st_q;
    logic [15:0] lane16;
    logic        wr_block;

    always_comb begin
        st_d     = st_q;
        evt_o    = '0;
        lane16   = big_endian_i ? wr_data_i : {wr_data_i[7:0], wr_data_i[15:8]};
        wr_block = (st_q.tx > WR_LIMIT);
        case (op_i)
            OP_WR16: begin
                if (!wr_block) begin
                    st_d.data     = (st_q.data << 16) | BUF_W'(lane16);
                    st_d.tx       = st_q.tx + CNT_W'(2);
                    evt_o.wr_ok   = 1'b1;
                    evt_o.wr_deep = (st_d.tx > WR_LIMIT);
                end
            end
            OP_WR8: begin
                if (!wr_block) begin
                    st_d.data     = (st_q.data << 8) | BUF_W'(wr_data_i[7:0]);
                    st_d.tx       = st_q.tx + CNT_W'(1);
                    evt_o.wr_ok   = 1'b1;
                    evt_o.wr_deep = (st_d.tx > WR_LIMIT);
                end
            end
            OP_TXPOP: begin
                if (st_q.tx != '0) st_d.tx = st_q.tx - CNT_W'(1);
            end
            OP_RXPUSH: begin
                if (st_q.rx < FULL) begin
                    for (int l = 0; l < NBYTES; l++) begin
                        if (st_q.rx == CNT_W'(l)) st_d.data[l*8 +: 8] = rx_byte_i;
                    end
                    st_d.rx     = st_q.rx + CNT_W'(1);
                    evt_o.rx_ok = 1'b1;
                end else begin
                    evt_o.rx_drop = 1'b1;
                end
            end
            OP_RD: begin
                evt_o.rd = 1'b1;
                if (st_q.rx == CNT_W'(1)) begin
                    st_d.rx         = '0;
                    evt_o.rd_single = 1'b1;
                end else if (st_q.rx > CNT_W'(1)) begin
                    if (st_q.rx > CNT_W'(2)) st_d.data = st_q.data >> 16;
                    st_d.rx = st_q.rx - CNT_W'(2);
                end
                evt_o.rd_drained = (st_d.rx == '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        tx_byte_o = '0;
        for (int l = 0; l < NBYTES; l++) begin
            if (st_q.tx == CNT_W'(l + 1)) tx_byte_o = st_q.data[l*8 +: 8];
        end
    end

    assign rd_data_o = big_endian_i ? {st_q.data[7:0], st_q.data[15:8]} : st_q.data[15:0];
    assign tx_cnt_o  = st_q.tx;
    assign rx_cnt_o  = st_q.rx;

    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_WR16 || op_i == OP_WR8) && st_q.tx > WR_LIMIT) |=> $stable(tx_cnt_o)); // R5
    AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt_o <= FULL); // R2
    AST_RX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RXPUSH && st_q.rx == FULL) |=> $stable(rx_cnt_o)); // R13
    AST_RD_ONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RD && st_q.rx == CNT_W'(1)) |=> (rx_cnt_o == '0)); // R9
    AST_RD_EMPTY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RD && st_q.rx == '0) |=> ($stable(rx_cnt_o) && $stable(tx_cnt_o))); // R12

endmodule

// File: rtl/stg_flags.sv
module stg_flags
    import stg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  evt_t       evt_i,
    input  logic       udf_set_i,
    input  logic       txr_set_i,
    input  logic [5:0] clr_i,
    input  logic       master_i,
    input  logic       dir_rx_i,
    output flags_t     flags_o,
    output logic       kick_o,
    output logic       mclr_o
);

    typedef struct packed {
        flags_t f;
        logic   kick;
        logic   mclr;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        fl_d      = fl_q;
        fl_d.f    = flags_t'(fl_q.f & ~clr_i);
        fl_d.kick = evt_i.rd;
        fl_d.mclr = 1'b0;
        if (udf_set_i) fl_d.f.udf = 1'b1;
        if (txr_set_i) fl_d.f.txr = 1'b1;
        if (evt_i.wr_ok) begin
            fl_d.f.udf = 1'b0;
            if (evt_i.wr_deep) fl_d.f.txr = 1'b0;
        end
        if (evt_i.rx_ok)   fl_d.f.rxr = 1'b1;
        if (evt_i.rx_drop) fl_d.f.ovr = 1'b1;
        if (evt_i.rd) begin
            fl_d.f.ovr = 1'b0;
            if (evt_i.rd_single) fl_d.f.single = 1'b1;
            if (evt_i.rd_drained) begin
                fl_d.f.rxr = 1'b0;
                if (master_i && dir_rx_i) begin
                    fl_d.f.acc = 1'b1;
                    fl_d.mclr  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags_o = fl_q.f;
    assign kick_o  = fl_q.kick;
    assign mclr_o  = fl_q.mclr;

    AST_RD_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.rd |=> !flags_o.ovr); // R11
    AST_RD_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.rd |=> kick_o); // R11
    AST_SINGLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.rd_single |=> flags_o.single); // R9
    AST_MCLR_WITH_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_o |-> flags_o.acc); // R10
    AST_WR_CLEARS_UDF: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.wr_ok |=> !flags_o.udf); // R6

endmodule

// File: rtl/stg_byte_buffer.sv
module stg_byte_buffer
    import stg_pkg::*;
#(
    parameter  int NBYTES = 4,
    localparam int CNT_W  = $clog2(NBYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             big_endian,
    input  logic             host_wr16,
    input  logic             host_wr8,
    input  logic [15:0]      host_wdata,
    input  logic             host_rd,
    output logic [15:0]      rd_data,
    input  logic             seq_tx_pop,
    output logic [7:0]       seq_tx_byte,
    input  logic             seq_rx_push,
    input  logic [7:0]       seq_rx_byte,
    input  logic             tx_udf_set,
    input  logic             tx_rdy_set,
    input  logic [5:0]       status_clr,
    input  logic             master_active,
    input  logic             dir_rx,
    output logic [CNT_W-1:0] tx_count,
    output logic [CNT_W-1:0] rx_count,
    output logic             flag_single,
    output logic             flag_overrun,
    output logic             flag_underflow,
    output logic             flag_tx_ready,
    output logic             flag_rx_ready,
    output logic             flag_access_ready,
    output logic             master_clr,
    output logic             seq_kick
);

    op_e    op;
    evt_t   evt;
    flags_t flags;

    always_comb begin
        if      (host_rd)     op = OP_RD;
        else if (host_wr16)   op = OP_WR16;
        else if (host_wr8)    op = OP_WR8;
        else if (seq_tx_pop)  op = OP_TXPOP;
        else if (seq_rx_push) op = OP_RXPUSH;
        else                  op = OP_IDLE;
    end

    stg_store #(.NBYTES(NBYTES)) i_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op),
        .big_endian_i (big_endian),
        .wr_data_i    (host_wdata),
        .rx_byte_i    (seq_rx_byte),
        .rd_data_o    (rd_data),
        .tx_byte_o    (seq_tx_byte),
        .tx_cnt_o     (tx_count),
        .rx_cnt_o     (rx_count),
        .evt_o        (evt)
    );

    stg_flags i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .udf_set_i (tx_udf_set),
        .txr_set_i (tx_rdy_set),
        .clr_i     (status_clr),
        .master_i  (master_active),
        .dir_rx_i  (dir_rx),
        .flags_o   (flags),
        .kick_o    (seq_kick),
        .mclr_o    (master_clr)
    );

    assign flag_single       = flags.single;
    assign flag_overrun      = flags.ovr;
    assign flag_underflow    = flags.udf;
    assign flag_tx_ready     = flags.txr;
    assign flag_rx_ready     = flags.rxr;
    assign flag_access_ready = flags.acc;

endmodule

// File: tb/test_stg_byte_buffer.sv
`timescale 1ns/1ps
module test_stg_byte_buffer;

    localparam int B_IDLE = 0, B_RD = 1, B_WR16 = 2, B_WR8 = 3, B_POP = 4, B_PUSH = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic big_endian = 0, host_wr16 = 0, host_wr8 = 0, host_rd = 0;
    logic [15:0] host_wdata = '0;
    logic seq_tx_pop = 0, seq_rx_push = 0, tx_udf_set = 0, tx_rdy_set = 0;
    logic [7:0] seq_rx_byte = '0;
    logic [5:0] status_clr = '0;
    logic master_active = 0, dir_rx = 0;
    logic [15:0] rd_data;
    logic [7:0] seq_tx_byte;
    logic [2:0] tx_count, rx_count;
    logic flag_single, flag_overrun, flag_underflow, flag_tx_ready, flag_rx_ready, flag_access_ready;
    logic master_clr, seq_kick;

    always #2.5 clk = ~clk;

    stg_byte_buffer i_stg_byte_buffer (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int last_got;

    logic [31:0] m_data = '0;
    int m_tx = 0, m_rx = 0;
    logic [5:0] m_fl = '0;   // 5 single,4 ovr,3 udf,2 txr,1 rxr,0 acc
    logic m_kick = 0, m_mclr = 0;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_state();
        chk("R2",  "tx_count", int'(tx_count), m_tx);
        chk("R8",  "rx_count", int'(rx_count), m_rx);
        chk("R9",  "single",   int'(flag_single), int'(m_fl[5]));
        chk("R13", "overrun",  int'(flag_overrun), int'(m_fl[4]));
        chk("R6",  "underflow", int'(flag_underflow), int'(m_fl[3]));
        chk("R6",  "tx_ready", int'(flag_tx_ready), int'(m_fl[2]));
        chk("R10", "rx_ready", int'(flag_rx_ready), int'(m_fl[1]));
        chk("R10", "access_ready", int'(flag_access_ready), int'(m_fl[0]));
        chk("R11", "seq_kick", int'(seq_kick), int'(m_kick));
        chk("R10", "master_clr", int'(master_clr), int'(m_mclr));
    endtask

    task automatic step(int op, logic [15:0] wd, logic be, logic ma, logic dr,
                        logic su, logic sr, logic [5:0] clr);
        logic [15:0] exp_rd;
        int new_tx, new_rx;
        @(negedge clk);
        check_state();
        host_rd = (op == B_RD); host_wr16 = (op == B_WR16); host_wr8 = (op == B_WR8);
        seq_tx_pop = (op == B_POP); seq_rx_push = (op == B_PUSH);
        host_wdata = wd; seq_rx_byte = wd[7:0]; big_endian = be;
        master_active = ma; dir_rx = dr; tx_udf_set = su; tx_rdy_set = sr; status_clr = clr;
        #0.5;
        exp_rd = be ? {m_data[7:0], m_data[15:8]} : m_data[15:0];
        if (op == B_RD) begin
            last_got = int'(rd_data);
            chk("R7", "rd_data", int'(rd_data), int'(exp_rd));
        end
        if (op == B_POP) begin
            last_got = int'(seq_tx_byte);
            chk("R2", "tx byte", int'(seq_tx_byte), m_tx > 0 ? int'(m_data[(m_tx-1)*8 +: 8]) : 0);
        end
        // model update
        m_fl = m_fl & ~clr;
        if (su) m_fl[3] = 1;
        if (sr) m_fl[2] = 1;
        m_kick = (op == B_RD);
        m_mclr = 0;
        case (op)
            B_WR16: if (m_tx <= 2) begin
                m_data = m_data << 16;
                if (be) m_data[15:0] = wd; else m_data[15:0] = {wd[7:0], wd[15:8]};
                m_tx += 2; m_fl[3] = 0;
                if (m_tx > 2) m_fl[2] = 0;
            end
            B_WR8: if (m_tx <= 2) begin
                m_data = {m_data[23:0], wd[7:0]};
                m_tx += 1; m_fl[3] = 0;
                if (m_tx > 2) m_fl[2] = 0;
            end
            B_POP: if (m_tx > 0) m_tx -= 1;
            B_PUSH: if (m_rx < 4) begin
                m_data[m_rx*8 +: 8] = wd[7:0]; m_rx += 1; m_fl[1] = 1;
            end else m_fl[4] = 1;
            B_RD: begin
                m_fl[4] = 0;
                if (m_rx == 1) begin m_rx = 0; m_fl[5] = 1; end
                else if (m_rx >= 2) begin
                    if (m_rx > 2) m_data = m_data >> 16;
                    m_rx -= 2;
                end
                if (m_rx == 0) begin
                    m_fl[1] = 0;
                    if (ma && dr) begin m_fl[0] = 1; m_mclr = 1; end
                end
            end
            default: ;
        endcase
    endtask

    task automatic do_idle();            step(B_IDLE, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic do_wr16(logic [15:0] v, logic be); step(B_WR16, v, be, 0, 0, 0, 0, 0); endtask
    task automatic do_wr8(logic [7:0] v); step(B_WR8, {8'h00, v}, 0, 0, 0, 0, 0, 0); endtask
    task automatic do_pop();             step(B_POP, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic do_push(logic [7:0] v); step(B_PUSH, {8'h00, v}, 0, 0, 0, 0, 0, 0); endtask
    task automatic do_rd(logic be, logic ma, logic dr); step(B_RD, 0, be, ma, dr, 0, 0, 0); endtask
    task automatic after_edge(); @(posedge clk); #1; endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0.5;
        // R1 reset state
        chk("R1", "tx_count", int'(tx_count), 0);
        chk("R1", "rx_count", int'(rx_count), 0);
        chk("R1", "flags", int'({flag_single, flag_overrun, flag_underflow, flag_tx_ready,
                                 flag_rx_ready, flag_access_ready, master_clr, seq_kick}), 0);
        chk("R1", "rd_data", int'(rd_data), 0);
        chk("R1", "tx byte", int'(seq_tx_byte), 0);

        // R2 little-endian order
        do_wr16(16'hA1B2, 0);
        do_pop(); after_edge(); chk("R2", "first sent", last_got, 'hB2);
        do_pop(); after_edge(); chk("R2", "second sent", last_got, 'hA1);
        // R3 big-endian order
        do_wr16(16'hA1B2, 1);
        do_pop(); after_edge(); chk("R3", "first sent", last_got, 'hA1);
        do_pop(); after_edge(); chk("R3", "second sent", last_got, 'hB2);

        // R6 write clears underflow, deep write clears tx ready
        step(B_IDLE, 0, 0, 0, 0, 1, 1, 0);
        do_wr8(8'h11); after_edge();
        chk("R6", "underflow after write", int'(flag_underflow), 0);
        chk("R6", "tx_ready kept at 1 byte", int'(flag_tx_ready), 1);
        chk("R4", "tx_count after byte", int'(tx_count), 1);
        do_wr16(16'h2233, 0); after_edge();
        chk("R6", "tx_ready after 3 bytes", int'(flag_tx_ready), 0);
        // R5 guarded writes
        step(B_IDLE, 0, 0, 0, 0, 1, 0, 0);
        do_wr16(16'h4455, 0);
        do_wr8(8'h66); after_edge();
        chk("R5", "tx_count held", int'(tx_count), 3);
        chk("R5", "underflow untouched", int'(flag_underflow), 1);
        do_pop(); after_edge(); chk("R4", "byte sent first", last_got, 'h11);
        do_pop(); after_edge(); chk("R5", "order kept", last_got, 'h33);
        do_pop(); after_edge(); chk("R5", "order kept", last_got, 'h22);

        // R7 R8 R9 R10 R11 R12 receive path
        do_push(8'hC1); do_push(8'hC2); do_push(8'hC3);
        do_rd(0, 1, 1); after_edge();
        chk("R7", "read low pair", last_got, 'hC2C1);
        chk("R8", "rx after 3-byte read", int'(rx_count), 1);
        do_rd(1, 1, 1); after_edge();
        chk("R7", "swapped lane0", last_got >> 8, 'hC3);
        chk("R9", "single flag", int'(flag_single), 1);
        chk("R9", "rx emptied", int'(rx_count), 0);
        chk("R10", "access ready", int'(flag_access_ready), 1);
        chk("R10", "master_clr pulse", int'(master_clr), 1);
        chk("R10", "rx_ready cleared", int'(flag_rx_ready), 0);
        chk("R11", "kick pulse", int'(seq_kick), 1);
        do_rd(0, 0, 0); after_edge();
        chk("R12", "stale read", last_got, int'(m_data[15:0]));
        chk("R12", "rx unchanged", int'(rx_count), 0);
        chk("R10", "no master_clr without master", int'(master_clr), 0);

        // R13 overrun, R11 read clears it
        for (int k = 0; k < 5; k++) do_push(8'(8'hD0 + k));
        after_edge();
        chk("R13", "overrun set", int'(flag_overrun), 1);
        chk("R13", "rx stays full", int'(rx_count), 4);
        do_rd(0, 0, 0); after_edge();
        chk("R11", "overrun cleared", int'(flag_overrun), 0);
        chk("R8", "rx after full read", int'(rx_count), 2);

        // R14 clear mask
        step(B_IDLE, 0, 0, 0, 0, 0, 0, 6'h3F); after_edge();
        chk("R14", "all flags cleared", int'({flag_single, flag_overrun, flag_underflow,
                                             flag_tx_ready, flag_rx_ready, flag_access_ready}), 0);
        step(B_IDLE, 0, 0, 0, 0, 1, 1, 6'h08); after_edge();
        chk("R14", "set beats clear", int'(flag_underflow), 1);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [5:0] clr;
            op  = $urandom_range(0, 5);
            clr = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'h00;
            step(op, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0), clr);
        end
        do_idle();
        do_idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog run hung actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule